// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Block

This block is the software-facing control and status window of one bus-master disk DMA channel. A host reaches an eight-byte window through a simple single-cycle bus that carries byte or aligned dword accesses. The window holds a command byte that starts and stops the transfer engine and picks its direction. It also holds a status byte and a 32-bit pointer to the descriptor table in memory.

The status byte combines fields with different access rules. One bit mirrors the engine's busy line and cannot be written. Two sticky event bits, error and interrupt, are set by the engine and cleared by software writing ones to them. Two plain read/write bits let software mark each of the two attached drives as able to use DMA. Software judges a finished transfer from the three low status bits read together. The block provides that judgement as an output, along with an interrupt line that follows the sticky interrupt bit.

Top module: `bmdma_regs`

## Requirements
- R1: After reset every readable byte of the window is zero, apart from status bit 0, which follows the engine busy input. eng_start, eng_to_mem, eng_table_ptr and irq_out are all low.
- R2: A write to offset 0 with data bit 0 = 1 raises eng_start on the next clock. A write with bit 0 = 0 drops it on the next clock.
- R3: Command bit 3 (1 = the engine writes memory) drives eng_to_mem. A write to bit 3 takes effect only when eng_start is low before the write. While eng_start is high, eng_to_mem holds its value.
- R4: Status bit 0 reads the eng_active input. Writes to status bit 0 have no effect.
- R5: A pulse on eng_err_set sets status bit 1, and a pulse on eng_irq_set sets status bit 2. Each bit stays set until software clears it.
- R6: Writing 1 to status bit 1 or bit 2 clears that bit, and writing 0 leaves it unchanged. If an engine event arrives in the same cycle as a clear of the same bit, the event wins and the bit stays set.
- R7: Status bits 5 and 6 are plain read/write flags for drive 0 and drive 1.
- R8: The descriptor pointer sits at offset 4. It is written by a dword or by single bytes at offsets 4 to 7, and it reads back with bits 1:0 always zero. eng_table_ptr drives its value.
- R9: Offsets 1 and 3, command bits 7:4 and 2:1, and status bits 7, 4 and 3 always read as zero. Writes to any of them change nothing.
- R10: xfer_ok is high exactly when status bits 2:0 read 100b: interrupt set, no error, engine not busy.
- R11: A dword access whose address has nonzero bits 1:0 is ignored. A write of that kind changes nothing, and a read of that kind returns zero.
- R12: irq_out follows status bit 2. Read data is registered and appears on bus_rdata the clock after the read. Byte reads return the byte in bits 7:0, and dword reads return offset 0 or offset 4 in little-endian order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_dword | input | 1 | 1 = dword access, 0 = byte access |
| bus_addr | input | 3 | Byte offset in the window |
| bus_wdata | input | 32 | Write data (byte writes use bits 7:0) |
| bus_rdata | output | 32 | Registered read data |
| eng_active | input | 1 | Engine busy |
| eng_err_set | input | 1 | Engine error event pulse |
| eng_irq_set | input | 1 | Engine completion event pulse |
| eng_start | output | 1 | Run the engine |
| eng_to_mem | output | 1 | Direction: 1 = drive to memory |
| eng_table_ptr | output | 32 | Descriptor table address |
| irq_out | output | 1 | Interrupt request |
| xfer_ok | output | 1 | Low status bits read 100b |

## Verification
The random traffic mixes byte and dword accesses at every offset, including misaligned dwords. This separates the lane decoding of the command, status and pointer bytes from the rules that drop an access. Writes with random data are made while the engine runs and while it is stopped. They show whether the direction bit stays locked while eng_start is high. Engine events collide with write-one-to-clear writes in the same cycle, which shows the event-wins priority. All eight combinations of busy, error and interrupt are visited, so xfer_ok is tested against every pattern that resembles the success code.

// File: rtl/bmdma_regs.sv
module bmdma_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_dword,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        eng_active,
  input  logic        eng_err_set,
  input  logic        eng_irq_set,
  output logic        eng_start,
  output logic        eng_to_mem,
  output logic [31:0] eng_table_ptr,
  output logic        irq_out,
  output logic        xfer_ok
);

  logic       run_q, dir_q, err_q, intr_q;
  logic [1:0] cap_q;
  logic [29:0] ptr_q;
  logic [7:0] lane_we;
  logic [7:0] lane_d [8];
  logic       aligned;
  logic [7:0] cmd_byte, stat_byte;
  logic [63:0] window;

  assign aligned = !bus_dword || (bus_addr[1:0] == 2'b00);

  always_comb begin
    for (int i = 0; i < 8; i++) begin
      lane_we[i] = bus_sel && bus_wr && aligned &&
                   (bus_dword ? (bus_addr[2] == i[2]) : (bus_addr == i[2:0]));
      lane_d[i]  = bus_dword ? bus_wdata[8*(i%4) +: 8] : bus_wdata[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      dir_q <= 1'b0;
    end else if (lane_we[0]) begin
      run_q <= lane_d[0][0];
      if (!run_q) dir_q <= lane_d[0][3];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      intr_q <= 1'b0;
      cap_q  <= 2'b00;
    end else begin
      err_q  <= eng_err_set || (err_q  && !(lane_we[2] && lane_d[2][1]));
      intr_q <= eng_irq_set || (intr_q && !(lane_we[2] && lane_d[2][2]));
      if (lane_we[2]) cap_q <= lane_d[2][6:5];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else begin
      if (lane_we[4]) ptr_q[5:0]   <= lane_d[4][7:2];
      if (lane_we[5]) ptr_q[13:6]  <= lane_d[5];
      if (lane_we[6]) ptr_q[21:14] <= lane_d[6];
      if (lane_we[7]) ptr_q[29:22] <= lane_d[7];
    end
  end

  assign cmd_byte  = {4'b0, dir_q, 2'b0, run_q};
  assign stat_byte = {1'b0, cap_q, 2'b0, intr_q, err_q, eng_active};
  assign window    = {ptr_q, 2'b00, 8'h00, stat_byte, 8'h00, cmd_byte};

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_sel && !bus_wr) begin
      if (!aligned)       bus_rdata <= '0;
      else if (bus_dword) bus_rdata <= window[32*bus_addr[2] +: 32];
      else                bus_rdata <= {24'h0, window[8*bus_addr +: 8]};
    end
  end

  assign eng_start     = run_q;
  assign eng_to_mem    = dir_q;
  assign eng_table_ptr = {ptr_q, 2'b00};
  assign irq_out       = intr_q;
  assign xfer_ok       = intr_q && !err_q && !eng_active;

endmodule

module bmdma_regs_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_sel,
  input logic bus_wr,
  input logic eng_active,
  input logic eng_irq_set,
  input logic eng_start,
  input logic eng_to_mem,
  input logic irq_out,
  input logic xfer_ok
);
  // R3
  dir_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> $stable(eng_to_mem));
  // R5
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_irq_set |=> irq_out);
  // R6
  irq_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_out && !eng_irq_set) |=> !irq_out);
  // R10
  ok_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ok |-> (irq_out && !eng_active));
  // R2
  start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_start && !(bus_sel && bus_wr)) |=> !eng_start);
endmodule

bind bmdma_regs bmdma_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .eng_active(eng_active), .eng_irq_set(eng_irq_set),
  .eng_start(eng_start), .eng_to_mem(eng_to_mem),
  .irq_out(irq_out), .xfer_ok(xfer_ok)
);

// File: tb/bmdma_regs_test.sv
`timescale 1ns/1ps
module bmdma_regs_test;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0, bus_dword = 0;
  logic [2:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic eng_active = 0, eng_err_set = 0, eng_irq_set = 0;
  logic eng_start, eng_to_mem, irq_out, xfer_ok;
  logic [31:0] eng_table_ptr;
  int tests = 0, fails = 0;

  // bench model
  logic m_run = 0, m_dir = 0, m_err = 0, m_intr = 0;
  logic [1:0] m_cap = 0;
  logic [31:0] m_ptr = 0;

  always #2.5 clk = ~clk;

  bmdma_regs uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_byte(input int off, input logic act);
    case (off)
      0: return {4'b0, m_dir, 2'b0, m_run};
      2: return {1'b0, m_cap, 2'b0, m_intr, m_err, act};
      4: return m_ptr[7:0];
      5: return m_ptr[15:8];
      6: return m_ptr[23:16];
      7: return m_ptr[31:24];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] m_read(input logic dw, input logic [2:0] a, input logic act);
    if (dw && a[1:0] != 0) return 32'h0;
    if (!dw) return {24'h0, m_byte(a, act)};
    return {m_byte(a+3, act), m_byte(a+2, act), m_byte(a+1, act), m_byte(a, act)};
  endfunction

  task automatic op(input logic sel, input logic wr, input logic dw, input logic [2:0] a,
                    input logic [31:0] wd, input logic act, input logic e, input logic q);
    logic [31:0] exp_rd;
    logic [7:0] bd;
    logic hit;
    @(negedge clk);
    bus_sel = sel; bus_wr = wr; bus_dword = dw; bus_addr = a; bus_wdata = wd;
    eng_active = act; eng_err_set = e; eng_irq_set = q;
    exp_rd = m_read(dw, a, act);
    @(posedge clk); #1;
    // model update
    begin
      logic clr_e, clr_i;
      clr_e = 0; clr_i = 0;
      if (sel && wr && !(dw && a[1:0] != 0)) begin
        for (int i = 0; i < 8; i++) begin
          hit = dw ? (a[2] == i[2]) : (a == i[2:0]);
          bd = dw ? wd[8*(i%4) +: 8] : wd[7:0];
          if (hit) case (i)
            0: begin if (!m_run) m_dir = bd[3]; m_run = bd[0]; end
            2: begin clr_e = bd[1]; clr_i = bd[2]; m_cap = bd[6:5]; end
            4: m_ptr[7:2] = bd[7:2];
            5: m_ptr[15:8] = bd;
            6: m_ptr[23:16] = bd;
            7: m_ptr[31:24] = bd;
            default: ;
          endcase
        end
      end
      m_err  = e | (m_err & ~clr_e);
      m_intr = q | (m_intr & ~clr_i);
    end
    if (sel && !wr) check(dw && a[1:0] != 0 ? "R11 misaligned read" : "R12 read data", bus_rdata, exp_rd);
    check("R2 eng_start", eng_start, m_run);
    check("R3 eng_to_mem", eng_to_mem, m_dir);
    check("R8 eng_table_ptr", eng_table_ptr, m_ptr);
    check("R5 R12 irq_out", irq_out, m_intr);
    check("R10 xfer_ok", xfer_ok, m_intr & ~m_err & ~act);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    op(1, 0, 1, 0, 0, 0, 0, 0);
    check("R1 reset dword0", bus_rdata, 32'h0);
    op(1, 0, 1, 4, 0, 0, 0, 0);
    check("R1 reset ptr", bus_rdata, 32'h0);
    // R2 / R3 directed
    op(1, 1, 0, 0, 32'h09, 0, 0, 0);
    check("R2 start set", eng_start, 1'b1);
    check("R3 dir set while stopped", eng_to_mem, 1'b1);
    op(1, 1, 0, 0, 32'h01, 1, 0, 0);
    check("R3 dir locked while running", eng_to_mem, 1'b1);
    op(1, 1, 0, 0, 32'h00, 0, 0, 0);
    check("R2 start clear", eng_start, 1'b0);
    check("R3 dir held when stopping", eng_to_mem, 1'b1);
    // R4 active read-only
    op(1, 1, 0, 2, 32'hFF, 1, 0, 0);
    op(1, 0, 0, 2, 0, 1, 0, 0);
    check("R4 R7 R9 status read", bus_rdata, 32'h61);
    // R5 / R6
    op(0, 0, 0, 0, 0, 0, 1, 1);
    op(1, 1, 0, 2, 32'h60, 0, 0, 0);
    check("R6 write zero keeps", irq_out, 1'b1);
    op(1, 1, 0, 2, 32'h64, 0, 0, 1);
    check("R6 set wins over clear", irq_out, 1'b1);
    op(1, 1, 0, 2, 32'h66, 0, 0, 0);
    check("R6 clear", irq_out, 1'b0);
    // R10 all combinations
    for (int k = 0; k < 8; k++) begin
      op(1, 1, 0, 2, 32'h06, 0, 0, 0);
      op(0, 0, 0, 0, 0, k[0], k[1], k[2]);
      op(1, 0, 0, 2, 0, k[0], 0, 0);
      check("R10 status low bits", bus_rdata[2:0], k[2:0]);
      check("R10 xfer_ok combo", xfer_ok, k[2:0] == 3'b100);
    end
    // R8 / R11 / R9
    op(1, 1, 1, 4, 32'hDEADBEEF, 0, 0, 0);
    check("R8 ptr low bits zero", eng_table_ptr, 32'hDEADBEEC);
    op(1, 1, 0, 6, 32'h5A, 0, 0, 0);
    check("R8 byte write", eng_table_ptr, 32'hDE5ABEEC);
    op(1, 1, 1, 5, 32'hFFFFFFFF, 0, 0, 0);
    check("R11 misaligned write ignored", eng_table_ptr, 32'hDE5ABEEC);
    op(1, 1, 0, 1, 32'hFF, 0, 0, 0);
    op(1, 0, 0, 1, 0, 0, 0, 0);
    check("R9 vendor byte zero", bus_rdata, 32'h0);
    // random
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] a;
      a = ($urandom % 4 == 0) ? 3'($urandom) : (($urandom % 2) ? 3'd0 : 3'd2);
      op($urandom % 4 != 0, $urandom % 2, $urandom % 3 == 0, a, $urandom,
         $urandom % 2, $urandom % 8 == 0, $urandom % 6 == 0);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule